// File: doc/BRIEF.md
# Duty-Cycle Code Interpolator

This block turns a fine converter code into a sequence of coarse codes for a converter with fewer bits. The fine code is split into a coarse base and a small fraction. Over a repeating cycle of equal-length phase slots, the output spends some slots at the base and the others at the base plus one. The fraction sets how many slots sit one step higher, so that after low-pass filtering in the analog domain the average level lands between two coarse steps.

Slot timing comes from a tick input, a periodic enable pulse from a rate generator elsewhere on the chip. A fixed number of ticks forms one slot, and four slots form one interpolation cycle. A new fine code can be written at any time with a write strobe. It goes into effect only at the next cycle boundary, so no cycle ever mixes two codes.

Top module: `ditr_interp`

## Requirements
- R1: During reset and on the first cycle after it, the output equals the coarse base of the reset code. That base is 0 when RESET_MID is 0, which is the default. The slot index is 0 and no switching is pending.
- R2: The coarse base C is taken from code bits 17:2 and the fraction F from code bits 1:0. For example, code 4094 gives C = 1023 and F = 2.
- R3: In slot index i (0 to 3) of a cycle, the output is C+1 when i < F and C otherwise.
- R4: When F is 0, the output stays at C in every slot, with no switching.
- R5: A slot lasts exactly TICKS_PER_SLOT tick pulses. The output changes only on the clock edge that samples the last tick of a slot.
- R6: A written code takes effect only in slot 0 of the next cycle, and the last write before that boundary wins. A write on the boundary edge itself takes effect at once.
- R7: When C is 0xFFFF and F is nonzero, the output stays at 0xFFFF in every slot. It never wraps to 0.
- R8: On clock edges without a tick, the output does not change.
- R9: Over whole cycles with one code, the number of slots at C+1 equals F per cycle, so the average equals C + F/4 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Rate enable pulse; TICKS_PER_SLOT of them form one slot |
| code_wr_i | input | 1 | Write strobe for code_i |
| code_i | input | 18 | Fine code: bits 17:2 coarse base, bits 1:0 fraction |
| dac_o | output | 16 | Coarse code to the converter |

## Verification
On every cycle, the checker ties the output to the active code and the slot index: the level in each slot, the steady output when the fraction is zero, and the clamp at full scale. It also checks that the output holds on edges without a tick and that the active code changes only as slot 0 begins. Only the bench's scenarios can show the rest. These are the slot length in ticks and which write wins at a cycle boundary. They also include the count of high slots over several cycles for each fraction value, which is the actual averaging property.

// File: rtl/ditr_pkg.sv
package ditr_pkg;

   localparam int DEF_BASE_W = 16;
   localparam int DEF_FRAC_W = 2;

   // Kind of level emitted in a slot
   typedef enum logic {
      LVL_BASE = 1'b0,
      LVL_BUMP = 1'b1
   } lvl_kind_e;

   // Slot idx sits one step up when it comes before the fraction count
   function automatic lvl_kind_e slot_kind(input int unsigned idx, input int unsigned frac);
      return (idx < frac) ? LVL_BUMP : LVL_BASE;
   endfunction

endpackage

// File: rtl/ditr_slot_timer.sv
module ditr_slot_timer #(
   parameter int TICKS_PER_SLOT = 5,
   parameter int FRAC_W         = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   output logic              slot_adv_o,
   output logic              cyc_start_o,
   output logic [FRAC_W-1:0] idx_o,
   output logic [FRAC_W-1:0] nxt_idx_o
);

   localparam int SUB_W = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;

   logic [FRAC_W-1:0] idx_q;

   generate
      if (TICKS_PER_SLOT == 1) begin : g_direct
         assign slot_adv_o = tick_i;
      end else begin : g_div
         logic [SUB_W-1:0] sub_q;
         logic             last_sub;

         assign last_sub   = (sub_q == SUB_W'(TICKS_PER_SLOT - 1));
         assign slot_adv_o = tick_i & last_sub;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sub_q <= '0;
            end else if (tick_i) begin
               if (last_sub) sub_q <= '0;
               else          sub_q <= sub_q + 1'b1;
            end
         end
      end
   endgenerate

   assign nxt_idx_o   = idx_q + 1'b1;
   assign cyc_start_o = slot_adv_o & (nxt_idx_o == '0);
   assign idx_o       = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          idx_q <= '0;
      else if (slot_adv_o) idx_q <= nxt_idx_o;
   end

endmodule

// File: rtl/ditr_code_hold.sv
module ditr_code_hold #(
   parameter int                        CODE_W     = 18,
   parameter logic [CODE_W-1:0]         RESET_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              load_i,
   output logic [CODE_W-1:0] act_o,
   output logic [CODE_W-1:0] nxt_act_o
);

   logic [CODE_W-1:0] pend_q;
   logic [CODE_W-1:0] act_q;
   logic [CODE_W-1:0] pend_fwd;

   // A write on the boundary edge is forwarded straight into the new cycle
   assign pend_fwd  = wr_i ? code_i : pend_q;
   assign nxt_act_o = load_i ? pend_fwd : act_q;
   assign act_o     = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= RESET_CODE;
         act_q  <= RESET_CODE;
      end else begin
         pend_q <= pend_fwd;
         act_q  <= nxt_act_o;
      end
   end

endmodule

// File: rtl/ditr_level_sel.sv
module ditr_level_sel
   import ditr_pkg::*;
#(
   parameter int BASE_W   = 16,
   parameter int FRAC_W   = 2,
   parameter bit SATURATE = 1'b1
) (
   input  logic [BASE_W+FRAC_W-1:0] code_i,
   input  logic [FRAC_W-1:0]        idx_i,
   output logic [BASE_W-1:0]        lvl_o
);

   logic [BASE_W-1:0] base;
   logic [FRAC_W-1:0] frac;
   logic [BASE_W-1:0] bumped;
   lvl_kind_e         kind;

   assign base = code_i[BASE_W+FRAC_W-1:FRAC_W];
   assign frac = code_i[FRAC_W-1:0];
   assign kind = slot_kind(int'(idx_i), int'(frac));

   generate
      if (SATURATE) begin : g_clamp
         assign bumped = (&base) ? base : base + 1'b1;
      end else begin : g_wrap
         assign bumped = base + 1'b1;
      end
   endgenerate

   assign lvl_o = (kind == LVL_BUMP) ? bumped : base;

endmodule

// File: rtl/ditr_interp.sv
module ditr_interp #(
   parameter int BASE_W         = ditr_pkg::DEF_BASE_W,
   parameter int FRAC_W         = ditr_pkg::DEF_FRAC_W,
   parameter int TICKS_PER_SLOT = 5,
   parameter bit RESET_MID      = 1'b0,
   parameter bit SATURATE       = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_i,
   input  logic                     code_wr_i,
   input  logic [BASE_W+FRAC_W-1:0] code_i,
   output logic [BASE_W-1:0]        dac_o
);

   localparam int                CODE_W     = BASE_W + FRAC_W;
   localparam logic [CODE_W-1:0] RESET_CODE = RESET_MID ? {1'b1, {(CODE_W-1){1'b0}}}
                                                        : {CODE_W{1'b0}};

   generate
      if (BASE_W < 2) begin : g_bad_base
         $error("ditr_interp: BASE_W must be at least 2");
      end
      if (FRAC_W < 1 || FRAC_W > 4) begin : g_bad_frac
         $error("ditr_interp: FRAC_W must be 1 to 4");
      end
      if (TICKS_PER_SLOT < 1) begin : g_bad_tps
         $error("ditr_interp: TICKS_PER_SLOT must be positive");
      end
   endgenerate

   logic              slot_adv;
   logic              cyc_start;
   logic [FRAC_W-1:0] slot_idx;
   logic [FRAC_W-1:0] nxt_idx;
   logic [CODE_W-1:0] act_code;
   logic [CODE_W-1:0] nxt_code;
   logic [BASE_W-1:0] nxt_lvl;
   logic [BASE_W-1:0] rst_lvl;
   logic [BASE_W-1:0] dac_q;

   ditr_slot_timer #(
      .TICKS_PER_SLOT (TICKS_PER_SLOT),
      .FRAC_W         (FRAC_W)
   ) timer_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .slot_adv_o  (slot_adv),
      .cyc_start_o (cyc_start),
      .idx_o       (slot_idx),
      .nxt_idx_o   (nxt_idx)
   );

   ditr_code_hold #(
      .CODE_W     (CODE_W),
      .RESET_CODE (RESET_CODE)
   ) hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (code_wr_i),
      .code_i    (code_i),
      .load_i    (cyc_start),
      .act_o     (act_code),
      .nxt_act_o (nxt_code)
   );

   ditr_level_sel #(
      .BASE_W   (BASE_W),
      .FRAC_W   (FRAC_W),
      .SATURATE (SATURATE)
   ) sel_next_i (
      .code_i (nxt_code),
      .idx_i  (nxt_idx),
      .lvl_o  (nxt_lvl)
   );

   ditr_level_sel #(
      .BASE_W   (BASE_W),
      .FRAC_W   (FRAC_W),
      .SATURATE (SATURATE)
   ) sel_rst_i (
      .code_i (RESET_CODE),
      .idx_i  ({FRAC_W{1'b0}}),
      .lvl_o  (rst_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dac_q <= rst_lvl;
      else if (slot_adv) dac_q <= nxt_lvl;
   end

   assign dac_o = dac_q;

endmodule

// File: rtl/ditr_interp_chk.sv
module ditr_interp_chk #(
   parameter int BASE_W   = 16,
   parameter int FRAC_W   = 2,
   parameter bit SATURATE = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     tick_i,
   input logic [BASE_W-1:0]        dac_o,
   input logic [BASE_W+FRAC_W-1:0] act_code,
   input logic [FRAC_W-1:0]        slot_idx
);

   logic [BASE_W-1:0] a_base;
   logic [FRAC_W-1:0] a_frac;
   logic [BASE_W-1:0] want;

   assign a_base = act_code[BASE_W+FRAC_W-1:FRAC_W];
   assign a_frac = act_code[FRAC_W-1:0];

   always_comb begin
      want = a_base;
      if (slot_idx < a_frac) begin
         if (SATURATE && (&a_base)) want = a_base;
         else                       want = a_base + 1'b1;
      end
   end

   // R3
   slot_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_o == want);

   // R4
   zero_frac_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_frac == '0) |-> (dac_o == a_base));

   // R7
   top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && (&a_base)) |-> (&dac_o));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(dac_o));

   // R6
   cycle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_code) |-> (slot_idx == '0));

endmodule

bind ditr_interp ditr_interp_chk #(
   .BASE_W   (BASE_W),
   .FRAC_W   (FRAC_W),
   .SATURATE (SATURATE)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_i   (tick_i),
   .dac_o    (dac_o),
   .act_code (act_code),
   .slot_idx (slot_idx)
);

// File: tb/ditr_interp_tb.sv
module ditr_interp_tb_top;

   localparam int TPS = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        code_wr_i = 1'b0;
   logic [17:0] code_i = '0;
   logic [15:0] dac_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // bench model state
   logic [17:0] pendm = '0;
   logic [17:0] actm = '0;
   int          tc = 0;

   always #10 clk = ~clk;

   ditr_interp #(
      .TICKS_PER_SLOT (TPS)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .code_wr_i (code_wr_i),
      .code_i    (code_i),
      .dac_o     (dac_o)
   );

   function automatic logic [15:0] exp_lvl(input logic [17:0] c, input int idx);
      logic [15:0] b;
      int          f;
      b = c[17:2];
      f = int'(c[1:0]);
      if (idx < f && b != 16'hFFFF) return b + 16'd1;
      return b;
   endfunction

   function automatic int cur_idx();
      return (tc / TPS) % 4;
   endfunction

   task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at tick %0d", tag, act, exp, tc);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // drive at negedge, model after posedge, compare at next negedge
   task automatic step(input bit tk, input bit wr, input logic [17:0] cd, input string tag);
      tick_i    = tk;
      code_wr_i = wr;
      code_i    = cd;
      @(posedge clk);
      if (wr) pendm = cd;
      if (tk) begin
         tc++;
         if (tc % TPS == 0 && cur_idx() == 0) actm = pendm;
      end
      @(negedge clk);
      tick_i    = 1'b0;
      code_wr_i = 1'b0;
      check16(tag, dac_o, exp_lvl(actm, cur_idx()));
   endtask

   task automatic to_cycle_start(input string tag);
      do step(1'b1, 1'b0, '0, tag); while (tc % (4 * TPS) != 0);
   endtask

   // write a code, let it take effect, then count levels over four cycles
   task automatic duty_run(input logic [17:0] cd, input string tag);
      int          hi;
      int          lo;
      logic [15:0] b;
      hi = 0;
      lo = 0;
      b  = cd[17:2];
      step(1'b0, 1'b1, cd, tag);
      to_cycle_start(tag);
      for (int s = 0; s < 16; s++) begin
         if (b != 16'hFFFF && dac_o == b + 16'd1) hi++;
         else if (dac_o == b)                     lo++;
         for (int t = 0; t < TPS; t++) step(1'b1, 1'b0, '0, tag);
      end
      check_int({tag, " high slots"}, hi, (b == 16'hFFFF) ? 0 : 4 * int'(cd[1:0]));
      check_int({tag, " total slots"}, hi + lo, 16);
   endtask

   initial begin : watchdog
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [15:0] held;
      int          seed;
      seed = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      // R1: reset state, reset code 0
      check16("R1 in reset", dac_o, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check16("R1 after reset", dac_o, 16'h0000);

      // R2: 4094 -> base 1023, fraction 2
      step(1'b0, 1'b1, 18'd4094, "R2");
      to_cycle_start("R2");
      check16("R2 slot0", dac_o, 16'd1024);
      for (int t = 0; t < 2 * TPS; t++) step(1'b1, 1'b0, '0, "R2");
      check16("R2 slot2", dac_o, 16'd1023);

      // R5: the output holds until the last tick of a slot
      to_cycle_start("R5");
      step(1'b0, 1'b1, 18'h00005, "R5");
      to_cycle_start("R5");
      held = dac_o;
      for (int t = 0; t < TPS - 1; t++) step(1'b1, 1'b0, '0, "R5");
      check16("R5 within slot", dac_o, held);
      step(1'b1, 1'b0, '0, "R5");
      check16("R5 slot edge", dac_o, 16'd1);

      // R8: edges without a tick leave the output alone
      held = dac_o;
      for (int t = 0; t < 7; t++) step(1'b0, 1'b0, '0, "R8");
      check16("R8 idle", dac_o, held);

      // R6: mid-cycle writes wait for the boundary; last write wins
      to_cycle_start("R6");
      step(1'b1, 1'b1, 18'h00400, "R6");
      step(1'b1, 1'b1, 18'h00803, "R6");
      check16("R6 old code kept", dac_o, exp_lvl(18'h00005, cur_idx()));
      to_cycle_start("R6");
      check16("R6 new code slot0", dac_o, 16'h0201);
      // write landing on the boundary edge itself
      while (tc % (4 * TPS) != 4 * TPS - 1) step(1'b1, 1'b0, '0, "R6");
      step(1'b1, 1'b1, 18'h00C00, "R6");
      check16("R6 boundary write", dac_o, 16'h0300);

      // R4 and R9: duty over whole cycles for every fraction
      duty_run(18'h12340, "R4 R9 F0");
      duty_run(18'h12341, "R9 F1");
      duty_run(18'h2ABC2, "R9 F2");
      duty_run(18'h00003, "R9 F3");

      // R7: full-scale base clamps
      duty_run(18'h3FFFF, "R7 F3");
      duty_run(18'h3FFFD, "R7 F1");
      duty_run(18'h3FFFB, "R9 below top F3");

      // R3: random codes, gapped ticks, random writes
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom % 100;
         step(r < 70, ($urandom % 23) == 0, 18'($urandom), "R3");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule